// File: doc/BRIEF.md
# Register-Immediate Arithmetic Core (64-bit)

This block is a small multi-cycle 64-bit integer core that runs only the register-immediate arithmetic group of the RISC-V base instruction set (major opcode 0x13). It holds a 32-entry by 64-bit general register file and a 64-bit program counter. It reads 32-bit instruction words through a single fetch port. Each instruction passes through a fetch, a decode and an execute state. No two instructions overlap.

The core stops when it meets an opcode it does not implement. It also stops when the program counter becomes zero after an instruction. In both cases it raises a sticky halted flag. An observation port reads any general register combinationally, so the surrounding logic can see the results. The start address and the memory size are parameters. The stack pointer (x2) comes out of reset holding the address just past the top of memory.

Top module: `imm_alu_core`

## Requirements
- R1: Register x0 always reads as zero; a result aimed at x0 is discarded.
- R2: While reset is held, every register reads zero except x2, which holds MEM_BASE + MEM_SIZE (default 0x80100000). The fetch address equals MEM_BASE (default 0x80000000), and halted is low.
- R3: Each instruction is fetched as the 32-bit word at the fetch address. The fetch address advances by 4 on the fetch clock edge, before the instruction executes.
- R4: Every instruction takes exactly three clocks. Its result is visible on the observation port after the third clock edge counted from the start of its fetch state. Two clocks after the synchronous reset release, the first fetch state begins.
- R5: Fields are decoded as follows: opcode inst[6:0] (0x13 selects this group), rd inst[11:7], funct3 inst[14:12] and rs1 inst[19:15]. The immediate is inst[31:20], sign-extended to 64 bits. funct3 0 adds, 4 XORs, 6 ORs and 7 ANDs the immediate with rs1.
- R6: funct3 1 shifts rs1 left by the 6-bit amount in inst[25:20].
- R7: funct3 5 shifts right by inst[25:20]. It is a logical shift when funct7 (inst[31:25], ignoring inst[25], which belongs to the amount) is 0x00, and an arithmetic shift when funct7 is 0x20.
- R8: funct3 2 writes 1 if rs1 is less than the immediate as signed values, else 0. funct3 3 makes the same comparison as unsigned values.
- R9: An opcode other than 0x13 writes no register and sets halted in that instruction's execute clock. Halted then stays set and the fetch address no longer changes.
- R10: If the fetch address is zero after an instruction has executed, that instruction's result is kept and the core halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_addr | output | 64 | Address of the next instruction word (program counter) |
| fetch_word | input | 32 | Instruction word at fetch_addr, sampled in the fetch state |
| halted | output | 1 | Sticky stop flag |
| peek_sel | input | 5 | Register index for the observation port |
| peek_data | output | 64 | Contents of the selected register (combinational) |

## Verification
The release takes two clocks to pass through the reset synchronizer, so the first fetch edge is the third edge after rst_n rises. After that edge the bench looks at fetch_addr on the falling edge and expects the +4 step. A result is due two edges later, on the execute edge, and the bench reads it through the observation port on the falling edge that follows. A halt caused by an unknown opcode is expected on the same execute edge: halted is sampled low one falling edge before it and high one falling edge after it. The zero-address halt runs in a second instance whose base lies 8 bytes below the wrap point, so the second instruction brings the address to zero.

// File: rtl/imm_core_pkg.sv
package imm_core_pkg;

  localparam int XLEN     = 64;
  localparam int ILEN     = 32;
  localparam int NREG     = 32;
  localparam int RIDX_W   = $clog2(NREG);
  localparam int SHAMT_W  = $clog2(XLEN);
  localparam int IMM_W    = 12;
  localparam int OPC_W    = 7;
  localparam int SP_INDEX = 2;

  localparam logic [OPC_W-1:0] OPC_ALU_IMM = 7'h13;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } core_state_e;

  typedef enum logic [3:0] {
    FN_ADD  = 4'd0,
    FN_SLL  = 4'd1,
    FN_SLT  = 4'd2,
    FN_SLTU = 4'd3,
    FN_XOR  = 4'd4,
    FN_SRL  = 4'd5,
    FN_SRA  = 4'd6,
    FN_OR   = 4'd7,
    FN_AND  = 4'd8
  } alu_fn_e;

  typedef struct packed {
    logic                legal;
    alu_fn_e             fn;
    logic [RIDX_W-1:0]   rd;
    logic [RIDX_W-1:0]   rs1;
    logic [XLEN-1:0]     imm;
    logic [SHAMT_W-1:0]  shamt;
  } dec_t;

endpackage

// File: rtl/imm_decoder.sv
module imm_decoder
  import imm_core_pkg::*;
(
  input  logic [ILEN-1:0] ir,
  output dec_t            dec
);

  logic [OPC_W-1:0] opcode;
  logic [2:0]       funct3;

  always_comb begin
    opcode    = ir[6:0];
    funct3    = ir[14:12];
    dec.legal = (opcode == OPC_ALU_IMM);
    dec.rd    = ir[11:7];
    dec.rs1   = ir[19:15];
    dec.imm   = {{(XLEN-IMM_W){ir[31]}}, ir[31:20]};
    dec.shamt = ir[20 +: SHAMT_W];
    unique case (funct3)
      3'd0:    dec.fn = FN_ADD;
      3'd1:    dec.fn = FN_SLL;
      3'd2:    dec.fn = FN_SLT;
      3'd3:    dec.fn = FN_SLTU;
      3'd4:    dec.fn = FN_XOR;
      3'd5:    dec.fn = ir[30] ? FN_SRA : FN_SRL;
      3'd6:    dec.fn = FN_OR;
      default: dec.fn = FN_AND;
    endcase
  end

endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_core_pkg::*;
(
  input  alu_fn_e             fn,
  input  logic [XLEN-1:0]     opa,
  input  logic [XLEN-1:0]     imm,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [XLEN-1:0]     result
);

  logic lt_signed;
  logic lt_unsigned;

  always_comb begin
    lt_signed   = ($signed(opa) < $signed(imm));
    lt_unsigned = (opa < imm);
    unique case (fn)
      FN_ADD:  result = opa + imm;
      FN_SLL:  result = opa << shamt;
      FN_SLT:  result = {{(XLEN-1){1'b0}}, lt_signed};
      FN_SLTU: result = {{(XLEN-1){1'b0}}, lt_unsigned};
      FN_XOR:  result = opa ^ imm;
      FN_SRL:  result = opa >> shamt;
      FN_SRA:  result = $unsigned($signed(opa) >>> shamt);
      FN_OR:   result = opa | imm;
      FN_AND:  result = opa & imm;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
  import imm_core_pkg::*;
#(
  parameter logic [XLEN-1:0] SP_INIT = 64'h0000_0000_8010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [RIDX_W-1:0] rd_idx_a,
  output logic [XLEN-1:0]   rd_data_a,
  input  logic [RIDX_W-1:0] rd_idx_b,
  output logic [XLEN-1:0]   rd_data_b
);

  logic [XLEN-1:0] rows [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    if (g == 0) begin : g_zero
      assign rows[g] = '0;
    end else begin : g_store
      localparam logic [XLEN-1:0] INIT_VAL = (g == SP_INDEX) ? SP_INIT : '0;
      logic row_en;
      assign row_en = wr_en && (wr_idx == RIDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rows[g] <= INIT_VAL;
        end else if (row_en) begin
          rows[g] <= wr_data;
        end
      end
    end
  end

  assign rd_data_a = rows[rd_idx_a];
  assign rd_data_b = rows[rd_idx_b];

endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
  import imm_core_pkg::*;
#(
  parameter logic [XLEN-1:0] MEM_BASE = 64'h0000_0000_8000_0000,
  parameter logic [XLEN-1:0] MEM_SIZE = 64'h0000_0000_0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   fetch_addr,
  input  logic [ILEN-1:0]   fetch_word,
  output logic              halted,
  input  logic [RIDX_W-1:0] peek_sel,
  output logic [XLEN-1:0]   peek_data
);

  localparam logic [XLEN-1:0] SP_TOP   = MEM_BASE + MEM_SIZE;
  localparam logic [XLEN-1:0] PC_STEP  = XLEN'(ILEN / 8);
  localparam int              SYNC_LEN = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_LEN-1:0] rst_sync;
  logic                core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_LEN-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync[SYNC_LEN-1];

  // state
  core_state_e       state_q, state_d;
  logic [XLEN-1:0]   pc_q, pc_d;
  logic [ILEN-1:0]   ir_q, ir_d;
  dec_t              dec_q, dec_d;
  logic [XLEN-1:0]   opa_q, opa_d;

  logic              pc_en, ir_en, dec_en;
  dec_t              dec_w;
  logic [XLEN-1:0]   rs1_val;
  logic [XLEN-1:0]   alu_out;
  logic              wb_en;

  imm_decoder u_dec (
    .ir  (ir_q),
    .dec (dec_w)
  );

  gp_regfile #(.SP_INIT(SP_TOP)) u_rf (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_en     (wb_en),
    .wr_idx    (dec_q.rd),
    .wr_data   (alu_out),
    .rd_idx_a  (dec_w.rs1),
    .rd_data_a (rs1_val),
    .rd_idx_b  (peek_sel),
    .rd_data_b (peek_data)
  );

  imm_alu u_alu (
    .fn     (dec_q.fn),
    .opa    (opa_q),
    .imm    (dec_q.imm),
    .shamt  (dec_q.shamt),
    .result (alu_out)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    pc_en   = 1'b0;
    ir_en   = 1'b0;
    dec_en  = 1'b0;
    wb_en   = 1'b0;
    pc_d    = pc_q + PC_STEP;
    ir_d    = fetch_word;
    dec_d   = dec_w;
    opa_d   = rs1_val;
    unique case (state_q)
      ST_FETCH: begin
        ir_en   = 1'b1;
        pc_en   = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        dec_en  = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (!dec_q.legal) begin
          state_d = ST_HALT;
        end else begin
          wb_en   = 1'b1;
          state_d = (pc_q == '0) ? ST_HALT : ST_FETCH;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= MEM_BASE;
      ir_q    <= '0;
      dec_q   <= '0;
      opa_q   <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= ir_d;
      if (dec_en) dec_q <= dec_d;
      if (dec_en) opa_q <= opa_d;
    end
  end

  assign fetch_addr = pc_q;
  assign halted     = (state_q == ST_HALT);

endmodule

// File: rtl/imm_alu_core_chk.sv
module imm_alu_core_chk
  import imm_core_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   fetch_addr,
  input logic              halted,
  input logic [RIDX_W-1:0] peek_sel,
  input logic [XLEN-1:0]   peek_data
);

  // R1
  x0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_sel == '0) |-> (peek_data == '0));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(fetch_addr));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fetch_addr) |-> (fetch_addr == $past(fetch_addr) + 64'd4));

  // R4
  pc_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fetch_addr) |=> $stable(fetch_addr));

endmodule

bind imm_alu_core imm_alu_core_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_addr (fetch_addr),
  .halted     (halted),
  .peek_sel   (peek_sel),
  .peek_data  (peek_data)
);

// File: tb/test_imm_alu_core.sv
module test_imm_alu_core;

  typedef struct packed {
    logic [11:0] imm;
    logic [4:0]  rs1;
    logic [2:0]  f3;
    logic [4:0]  rd;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam logic [63:0] BASE_A = 64'h0000_0000_8000_0000;
  localparam logic [63:0] BASE_B = 64'hFFFF_FFFF_FFFF_FFF8;

  // program executed in order; each entry is one instruction and its rd result
  localparam vec_t VECS [NV] = '{
    '{12'hFFF, 5'd0,  3'd0, 5'd1,  64'hFFFF_FFFF_FFFF_FFFF}, // R5 addi -1
    '{12'h7FF, 5'd0,  3'd0, 5'd3,  64'h0000_0000_0000_07FF}, // R5 addi max
    '{12'h034, 5'd3,  3'd1, 5'd4,  64'h7FF0_0000_0000_0000}, // R6 slli 52
    '{12'h03C, 5'd1,  3'd5, 5'd5,  64'h0000_0000_0000_000F}, // R7 srli 60
    '{12'h404, 5'd1,  3'd5, 5'd6,  64'hFFFF_FFFF_FFFF_FFFF}, // R7 srai 4
    '{12'h438, 5'd4,  3'd5, 5'd7,  64'h0000_0000_0000_007F}, // R7 srai 56 positive
    '{12'h035, 5'd3,  3'd1, 5'd9,  64'hFFE0_0000_0000_0000}, // R6 slli 53
    '{12'h434, 5'd9,  3'd5, 5'd10, 64'hFFFF_FFFF_FFFF_FFFE}, // R7 srai 52 negative
    '{12'h034, 5'd9,  3'd5, 5'd11, 64'h0000_0000_0000_0FFE}, // R7 srli 52
    '{12'h000, 5'd1,  3'd2, 5'd12, 64'h1},                   // R8 slti -1<0
    '{12'h000, 5'd1,  3'd3, 5'd13, 64'h0},                   // R8 sltiu max<0
    '{12'hFFF, 5'd3,  3'd3, 5'd14, 64'h1},                   // R8 sltiu 7ff<max
    '{12'hFFF, 5'd3,  3'd2, 5'd15, 64'h0},                   // R8 slti 7ff<-1
    '{12'hFFF, 5'd3,  3'd4, 5'd16, 64'hFFFF_FFFF_FFFF_F800}, // R5 xori
    '{12'h030, 5'd5,  3'd6, 5'd17, 64'h0000_0000_0000_003F}, // R5 ori
    '{12'h555, 5'd1,  3'd7, 5'd18, 64'h0000_0000_0000_0555}, // R5 andi
    '{12'h7FF, 5'd16, 3'd7, 5'd19, 64'h0},                   // R5 andi disjoint
    '{12'h005, 5'd3,  3'd0, 5'd0,  64'h0},                   // R1 write to x0
    '{12'hFF0, 5'd2,  3'd0, 5'd20, 64'h0000_0000_800F_FFF0}, // R2 sp based
    '{12'h800, 5'd9,  3'd2, 5'd21, 64'h1},                   // R8 slti vs -2048
    '{12'h001, 5'd1,  3'd0, 5'd22, 64'h0}                    // R5 add wraps
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] fa_a, fa_b, pd_a, pd_b;
  logic [31:0] fw_a, fw_b;
  logic        hlt_a, hlt_b;
  logic [4:0]  ps_a, ps_b;
  logic [31:0] prog_a [32];
  logic [31:0] prog_b [32];

  int checks;
  int failures;
  int cyc;

  assign fw_a = prog_a[fa_a[6:2]];
  assign fw_b = prog_b[fa_b[6:2]];

  imm_alu_core i_imm_alu_core (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fa_a), .fetch_word(fw_a),
    .halted(hlt_a), .peek_sel(ps_a), .peek_data(pd_a));

  imm_alu_core #(.MEM_BASE(BASE_B)) i_imm_alu_core_wrap (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fa_b), .fetch_word(fw_b),
    .halted(hlt_b), .peek_sel(ps_b), .peek_data(pd_b));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input vec_t v);
    return {v.imm, v.rs1, v.f3, v.rd, 7'h13};
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      finish_run();
    end
  end

  initial begin
    checks = 0; failures = 0; cyc = 0;
    rst_n = 1'b0;
    ps_a = 5'd0; ps_b = 5'd0;
    for (int i = 0; i < 32; i++) begin
      prog_a[i] = 32'h0;
      prog_b[i] = 32'h0;
    end
    for (int i = 0; i < NV; i++) prog_a[i] = enc(VECS[i]);
    prog_a[NV] = {7'h00, 5'd3, 5'd3, 3'd0, 5'd23, 7'h33}; // unknown opcode, rd x23
    prog_b[30] = {12'd5,   5'd0, 3'd0, 5'd1, 7'h13};     // addi x1,x0,5
    prog_b[31] = {12'd1,   5'd1, 3'd0, 5'd1, 7'h13};     // addi x1,x1,1 -> pc 0
    prog_b[0]  = {12'd100, 5'd1, 3'd0, 5'd1, 7'h13};     // must not run

    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 pc", fa_a, BASE_A);
    chk("R2 halted", {63'b0, hlt_a}, 64'h0);
    ps_a = 5'd2; #1;
    chk("R2 sp", pd_a, 64'h0000_0000_8010_0000);
    ps_a = 5'd5; #1;
    chk("R2 other reg", pd_a, 64'h0);
    ps_b = 5'd2; #1;
    chk("R2 sp wrap instance", pd_b, 64'h0000_0000_000F_FFF8);

    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);              // fetch edge
      @(negedge clk);
      chk("R3 pc advance at fetch", fa_a, BASE_A + 64'(4 * (i + 1)));
      if (i == 1) chk("R10 no early halt", {63'b0, hlt_b}, 64'h0);
      ps_a = VECS[i].rd;
      #1;
      if (i == 0) chk("R4 not before execute", pd_a, 64'h0);
      @(posedge clk);              // decode edge
      @(posedge clk);              // execute edge
      @(negedge clk);
      chk($sformatf("R4/R5-R8 vector %0d", i), pd_a, VECS[i].exp);
    end

    // R1 x0 through the port
    ps_a = 5'd0; #1;
    chk("R1 x0 reads zero", pd_a, 64'h0);

    // R9 unknown opcode
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R9 not halted before execute", {63'b0, hlt_a}, 64'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 halted at execute", {63'b0, hlt_a}, 64'h1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R9 halt sticky", {63'b0, hlt_a}, 64'h1);
    chk("R9 fetch frozen", fa_a, BASE_A + 64'(4 * (NV + 1)));
    ps_a = 5'd23; #1;
    chk("R9 no write", pd_a, 64'h0);

    // R10 pc reaches zero in the wrap instance
    chk("R10 halted", {63'b0, hlt_b}, 64'h1);
    chk("R10 pc zero", fa_b, 64'h0);
    ps_b = 5'd1; #1;
    chk("R10 last result kept", pd_b, 64'd6);

    finish_run();
  end

endmodule